// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block guards a processor against runaway code. A 13-bit prescaler counts timer-clock enable pulses. One of eight prescaler taps, chosen by a 3-bit select, decrements an 8-bit main counter. If the main counter is at zero when a decrement arrives, the block pulses a reset request, sets a time-out flag and reloads the counter from a software-written reload register. The reload also clears the prescaler, so any reload value from 00h to FFh is valid. The time-out period is (W+1) times the divisor.

Software restarts the countdown with a keyed two-write feed. It first writes A5h to the first key register and then writes 5Ah to the second key register on the very next bus access. A correct feed reloads the counter and also commits any pending control write: divisor select and run bit are written to a shadow copy and only take effect when a feed is accepted. A wrong second key, or any other bus access while the first key is armed, requests a reset at once. Clearing the run bit and then feeding freezes the watchdog. After reset the watchdog runs at the longest divisor with reload value 0.

Top module: `wdog_top`

Register addresses on `busAddr` are 0 for reload, 1 for control, 2 for the first key and 3 for the second key. The control byte places the divisor select in bits 7:5, the run bit in bit 2 and the time-out flag in bit 1. All other control bits read 0.

## Requirements
- R1: After an autoload, the main counter underflows on the (W+1)*D-th clock edge at which `tickEn` is high, counted from the edge after the autoload. W is the reload value and D is the divisor. `resetReq` is then high for exactly the one cycle after that edge.
- R2: The divisor D is 32 << sel, where sel is control bits 7:5. This gives 32 for code 000 up to 4096 for code 111.
- R3: An underflow sets the time-out flag (control bit 1), reloads the counter and clears the prescaler, so counting continues with the same period.
- R4: A feed consists of writing A5h to address 2 and then 5Ah to address 3 on the next bus access. It reloads the counter from the reload register and clears the prescaler.
- R5: While armed by A5h at address 2, any next access other than a 5Ah write to address 3 drives `resetReq` high in the following cycle and disarms the sequence. This covers reads, writes to other addresses and a wrong key value.
- R6: A write to address 2 with a value other than A5h, and a write to address 3 while not armed, cause no reset request and do not commit pending control settings.
- R7: Writes to control bits 7:5 and bit 2 go to a shadow copy. Readback and behaviour keep the old settings until a feed is accepted.
- R8: With the run bit at 0, the prescaler and counter hold their values and no underflow reset request is raised.
- R9: The time-out flag is cleared at once by a control write with bit 1 at 0. Writing 1 to bit 1 does not change it.
- R10: After reset, control reads E4h (sel 111, run 1, flag 0), reload reads 00h, `resetReq` is 0 and the first time-out comes 4096 enabled ticks after reset.
- R11: Addresses 2 and 3 read 00h, and the reload register reads back the last value written.
- R12: Asserting `rstN` just after an underflow clears the time-out flag and the reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer-clock enable, one prescaler count per high cycle |
| busSel | input | 1 | Bus access strobe, one access per high cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| resetReq | output | 1 | One-cycle watchdog reset request |

## Verification
The bench measures time-out intervals in enabled ticks across divisor codes and reload values, including reload 0 and random gaps in `tickEn`. An off-by-one in the tap or a prescaler that is not cleared on autoload would shift the measured interval. The shadowed control register is probed by reading back before and after a feed, and again after sequences that must be ignored. A design that committed control writes directly, or accepted a feed without the first key, would show the new value too early. Wrong second keys and interposed reads must each produce a reset pulse, and a stopped watchdog must stay silent over thousands of ticks. A reset right after an underflow must leave the flag clear.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SEL_W = 3;
  localparam int NUM_TAPS = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_KEY1 = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_KEY2 = 2'd3;

  localparam logic [DATA_W-1:0] KEY1_VAL = 8'hA5;
  localparam logic [DATA_W-1:0] KEY2_VAL = 8'h5A;

  localparam int SEL_LSB = 5;
  localparam int RUN_BIT = 2;
  localparam int FLAG_BIT = 1;

  typedef struct packed {
    logic autoload;
    logic run;
    logic [SEL_W-1:0] preSel;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int BASE_SHIFT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  wdStrobe_t strobe,
  input  logic [DATA_W-1:0] reloadVal,
  output logic underflow
);
  localparam int TOP_TAP = BASE_SHIFT + NUM_TAPS - 1;

  logic [PRE_W-1:0] prescaler;
  logic [DATA_W-1:0] count;
  logic [NUM_TAPS-1:0] tapHit;
  logic tick;

  initial begin
    if (TOP_TAP > PRE_W) $error("prescaler too narrow for tap range");
  end

  for (genvar s = 0; s < NUM_TAPS; s++) begin : gTap
    assign tapHit[s] = &prescaler[BASE_SHIFT+s-1:0];
  end

  always_comb begin
    tick = tickEn & strobe.run & tapHit[strobe.preSel];
    underflow = tick & (count == '0) & ~strobe.autoload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaler <= '0;
      count <= '0;
    end else if (strobe.autoload || underflow) begin
      prescaler <= '0;
      count <= reloadVal;
    end else if (tickEn && strobe.run) begin
      prescaler <= prescaler + 1'b1;
      if (tick) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busSel,
  input  logic busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic underflow,
  output wdStrobe_t strobe,
  output logic [DATA_W-1:0] reloadVal,
  output logic resetReq
);
  logic [SEL_W-1:0] activeSel, shadowSel;
  logic activeRun, shadowRun;
  logic toFlag;
  logic armed;
  logic wrAny, wrReload, wrCtrl, armNow, goodKey2, feedOk, feedBad;

  always_comb begin
    wrAny = busSel & busWe;
    wrReload = wrAny & (busAddr == ADDR_RELOAD);
    wrCtrl = wrAny & (busAddr == ADDR_CTRL);
    armNow = ~armed & wrAny & (busAddr == ADDR_KEY1) & (busWdata == KEY1_VAL);
    goodKey2 = wrAny & (busAddr == ADDR_KEY2) & (busWdata == KEY2_VAL);
    feedOk = armed & goodKey2;
    feedBad = armed & busSel & ~goodKey2;
    strobe.autoload = feedOk;
    strobe.run = activeRun;
    strobe.preSel = activeSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
      activeSel <= '1;
      shadowSel <= '1;
      activeRun <= 1'b1;
      shadowRun <= 1'b1;
      toFlag <= 1'b0;
      armed <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      resetReq <= underflow | feedBad;
      if (wrReload) reloadVal <= busWdata;
      if (wrCtrl) begin
        shadowSel <= busWdata[SEL_LSB +: SEL_W];
        shadowRun <= busWdata[RUN_BIT];
      end
      if (feedOk) begin
        activeSel <= shadowSel;
        activeRun <= shadowRun;
      end
      if (underflow) toFlag <= 1'b1;
      else if (wrCtrl && !busWdata[FLAG_BIT]) toFlag <= 1'b0;
      if (armed && busSel) armed <= 1'b0;
      else if (armNow) armed <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_RELOAD: busRdata = reloadVal;
      ADDR_CTRL: begin
        busRdata[SEL_LSB +: SEL_W] = activeSel;
        busRdata[RUN_BIT] = activeRun;
        busRdata[FLAG_BIT] = toFlag;
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int BASE_SHIFT = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic busSel,
  input  logic busWe,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic resetReq
);
  wdStrobe_t strobe;
  logic [DATA_W-1:0] reloadVal;
  logic underflow;

  wdog_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .underflow(underflow), .strobe(strobe), .reloadVal(reloadVal),
    .resetReq(resetReq)
  );

  wdog_dp #(.PRE_W(PRE_W), .BASE_SHIFT(BASE_SHIFT)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .reloadVal(reloadVal), .underflow(underflow)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int PRE_W = 13
) (
  input logic clk,
  input logic rstN,
  input logic busSel,
  input logic busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic resetReq,
  input logic underflow,
  input wdStrobe_t strobe,
  input logic [DATA_W-1:0] reloadVal,
  input logic [DATA_W-1:0] count,
  input logic [PRE_W-1:0] prescaler,
  input logic armed,
  input logic toFlag
);
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> toFlag);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.autoload && !underflow) |=>
      (count == $past(count) || count == $past(count) - 8'd1));

  p_autoload_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.autoload |=> (prescaler == '0 && count == $past(reloadVal)));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.autoload) |=> ($stable(count) && $stable(prescaler)));

  p_bad_feed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && busSel && !(busWe && busAddr == ADDR_KEY2 && busWdata == KEY2_VAL))
      |=> resetReq);

  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(underflow || (armed && busSel)));

  p_key_read_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_KEY1 || busAddr == ADDR_KEY2) |-> busRdata == '0);
endmodule

bind wdog_top wdog_chk #(.PRE_W(PRE_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .resetReq(resetReq), .underflow(underflow), .strobe(strobe),
  .reloadVal(reloadVal), .count(uDp.count), .prescaler(uDp.prescaler),
  .armed(uCtrl.armed), .toFlag(uCtrl.toFlag)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic busSel = 1'b0;
  logic busWe = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic resetReq;
  int checks = 0;
  int errors = 0;
  bit randTick = 0;

  always #10 clk = ~clk;

  wdog_top dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .resetReq(resetReq)
  );

  function automatic int expTimeout(input int w, input int sel);
    return (w + 1) * (32 << sel);
  endfunction

  function automatic logic [7:0] ctrlByte(input int sel, input bit run, input bit flag);
    return {sel[2:0], 2'b00, run, flag, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busSel = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic feed();
    busSel = 1; busWe = 1; busAddr = 2'd2; busWdata = 8'hA5;
    @(negedge clk);
    busAddr = 2'd3; busWdata = 8'h5A;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic measure(output int n);
    n = 0;
    tickEn = randTick ? 1'($urandom % 2) : 1'b1;
    forever begin
      @(posedge clk);
      if (tickEn) n++;
      @(negedge clk);
      if (resetReq || n > 20000) break;
      tickEn = randTick ? 1'($urandom % 2) : 1'b1;
    end
    tickEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10 / R11: reset state
    peek(2'd1, d); check(d == 8'hE4, "R10 ctrl reset", d, 8'hE4);
    peek(2'd0, d); check(d == 8'h00, "R10 reload reset", d, 0);
    check(resetReq == 0, "R10 no request", resetReq, 0);
    peek(2'd2, d); check(d == 0, "R11 key1 reads 0", d, 0);
    peek(2'd3, d); check(d == 0, "R11 key2 reads 0", d, 0);
    // R10 / R1: first time-out at the largest divisor
    measure(n); check(n == 4096, "R10 first timeout", n, 4096);
    @(negedge clk); check(resetReq == 0, "R1 single pulse", resetReq, 0);
    readReg(2'd1, d); check(d == 8'hE6, "R3 flag set", d, 8'hE6);
    writeReg(2'd1, 8'hE6);
    readReg(2'd1, d); check(d == 8'hE6, "R9 write 1 keeps flag", d, 8'hE6);
    writeReg(2'd1, 8'hE4);
    readReg(2'd1, d); check(d == 8'hE4, "R9 flag cleared", d, 8'hE4);
    // R7 shadow, R2 divisor, R4 feed
    writeReg(2'd0, 8'd3);
    writeReg(2'd1, ctrlByte(1, 1, 0));
    readReg(2'd1, d); check(d == 8'hE4, "R7 shadow held", d, 8'hE4);
    readReg(2'd0, d); check(d == 8'd3, "R11 reload readback", d, 3);
    feed();
    readReg(2'd1, d); check(d == 8'h24, "R7 committed on feed", d, 8'h24);
    measure(n); check(n == expTimeout(3, 1), "R4 R2 timeout after feed", n, expTimeout(3, 1));
    measure(n); check(n == expTimeout(3, 1), "R3 period repeats", n, expTimeout(3, 1));
    // R6 ignored sequences
    writeReg(2'd1, ctrlByte(0, 1, 0));
    writeReg(2'd2, 8'h11); check(resetReq == 0, "R6 wrong key1 no request", resetReq, 0);
    writeReg(2'd3, 8'h5A); check(resetReq == 0, "R6 lone key2 no request", resetReq, 0);
    readReg(2'd1, d); check(d == 8'h24, "R6 no commit", d, 8'h24);
    feed();
    readReg(2'd1, d); check(d == 8'h04, "R7 commit sel0", d, 8'h04);
    // R5 bad feeds
    writeReg(2'd2, 8'hA5);
    writeReg(2'd3, 8'h33); check(resetReq == 1, "R5 wrong key2", resetReq, 1);
    @(negedge clk); check(resetReq == 0, "R5 pulse ends", resetReq, 0);
    writeReg(2'd2, 8'hA5);
    readReg(2'd0, d); check(resetReq == 1, "R5 interposed read", resetReq, 1);
    writeReg(2'd2, 8'hA5);
    writeReg(2'd0, 8'h01); check(resetReq == 1, "R5 interposed write", resetReq, 1);
    // R8 stopped watchdog
    writeReg(2'd1, ctrlByte(0, 0, 0));
    feed();
    tickEn = 1;
    n = 0;
    repeat (6000) begin
      @(negedge clk);
      if (resetReq) n++;
    end
    tickEn = 0;
    check(n == 0, "R8 frozen no request", n, 0);
    readReg(2'd1, d); check(d == 8'h00, "R8 run off readback", d, 0);
    // R1 / R2 random divisors, reloads and tick gaps
    randTick = 1;
    for (int i = 0; i < 6; i++) begin
      int sel, w;
      sel = $urandom % 4;
      w = $urandom % 6;
      writeReg(2'd0, 8'(w));
      writeReg(2'd1, ctrlByte(sel, 1, 0));
      feed();
      measure(n);
      check(n == expTimeout(w, sel), "R1 R2 random timeout", n, expTimeout(w, sel));
    end
    randTick = 0;
    // R1 reload of zero
    writeReg(2'd0, 8'd0);
    writeReg(2'd1, ctrlByte(0, 1, 0));
    feed();
    measure(n); check(n == 32, "R1 reload zero", n, 32);
    // R12 reset right after an underflow
    rstN = 0;
    #1 check(resetReq == 0, "R12 request cleared", resetReq, 0);
    @(negedge clk);
    rstN = 1;
    peek(2'd1, d); check(d == 8'hE4, "R12 flag cleared", d, 8'hE4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule